// File: doc/BRIEF.md
# Gen2 Link Stall Recovery Monitor

This block supervises a link while it climbs from L0 to a faster signalling rate. It watches two debug words from the link controller, taking a link-up flag from one and the 6-bit training state from the other. It also watches a receive-valid indication from the PHY. Once the link has been up for a settle interval, the block looks for one specific stall: training is parked in the receiver-lock recovery state while the receiver reports no valid data.

When that stall appears, the block forces the PHY receiver out of it. Through a request/done port toward the PHY register access engine, it does a read-modify-write of the receiver override register at PHY address 0x1005, setting the receiver data-enable bit and the receiver PLL-enable bit. It holds that state for a fixed interval. It then does a second read-modify-write that clears both bits, so that training can resume. A stuck flag is high for the whole recovery pulse, and a saturating counter records how many pulses have been issued. All delays are counted in clock cycles and set by parameters. The defaults are about 2 ms of settle and 2.5 ms of hold at 125 MHz.

Top module: `link_stall_guard`

## Requirements
- R1: After reset, `stuck` is 0, `retries` is 0 and `phy_req` is 0.
- R2: Link-up is bit 4 of `dbg_hi`. The training state is `dbg_lo[5:0]`. All other bits of both words have no effect.
- R3: No stall is acted on until link-up has been seen high on SETTLE_CYC consecutive clock edges. If link-up drops during that interval, the count starts again. With link-up first sampled high at edge k and a stall present throughout, `stuck` rises after edge k+SETTLE_CYC+1.
- R4: A stall is the training state equal to STALL_CODE (default 0x0D) with `rx_valid` at 0, while link-up is high. If link-up falls in the same cycle that a stall appears, the stall is ignored.
- R5: Recovery starts with a read of PHY address OVRD_ADDR (0x1005). It is followed by a write to the same address of the read value with bit 5 and bit 3 set.
- R6: The next request, a read, rises exactly HOLD_CYC clock edges after the edge that samples `phy_done` for the setting write.
- R7: The second read of OVRD_ADDR is followed by a write of that freshly read value with bit 5 and bit 3 cleared.
- R8: Each request holds `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` steady until `phy_done`. `stuck` is 1 from the cycle after stall detection until the clearing write completes, and 0 otherwise.
- R9: `retries` increments by one each time a setting write completes, and saturates at its all-ones value.
- R10: Once started, a recovery pulse runs to completion even if link-up drops. Afterwards the block waits for a fresh settle interval before checking again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_lo | input | 32 | First debug word; training state in bits 5:0 |
| dbg_hi | input | 32 | Second debug word; link-up in bit 4 |
| rx_valid | input | 1 | PHY receiver valid indication |
| phy_req | output | 1 | PHY register access request, held until done |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_rdata | input | 16 | Read data, valid with phy_done |
| phy_done | input | 1 | One-cycle completion of the current request |
| stuck | output | 1 | Recovery pulse in progress |
| retries | output | CNT_W | Saturating count of recovery pulses |

## Verification
Two things can land on the same cycle here: link-up falling, and a stall appearing while the block is watching. The bench raises the link with no stall and lets the settle interval run out. On one negedge it then drops link-up and pulls `rx_valid` low together, and it judges by the ports: no PHY request, `stuck` stays 0 and `retries` is unchanged. Link loss can also overlap an active hold. That case is provoked by dropping link-up right after the setting write, and it is judged by the clearing write still arriving with the expected value and hold spacing.

// File: rtl/link_stall_guard.sv
module link_stall_guard #(
  parameter int          SETTLE_CYC  = 250000,
  parameter int          HOLD_CYC    = 312500,
  parameter int          CNT_W       = 8,
  parameter logic [5:0]  STALL_CODE  = 6'h0D,
  parameter logic [15:0] OVRD_ADDR   = 16'h1005,
  parameter int          DATA_EN_BIT = 5,
  parameter int          PLL_EN_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      dbg_lo,
  input  logic [31:0]      dbg_hi,
  input  logic             rx_valid,
  output logic             phy_req,
  output logic             phy_we,
  output logic [15:0]      phy_addr,
  output logic [15:0]      phy_wdata,
  input  logic [15:0]      phy_rdata,
  input  logic             phy_done,
  output logic             stuck,
  output logic [CNT_W-1:0] retries
);
  localparam int TMAX = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [15:0] MASK = (16'd1 << DATA_EN_BIT) | (16'd1 << PLL_EN_BIT);
  localparam logic [TW-1:0] SETTLE_END = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] HOLD_END   = TW'(HOLD_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_WATCH, S_RD_SET, S_WR_SET, S_HOLD, S_RD_CLR, S_WR_CLR
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [15:0]   shadow;

  wire lnk   = dbg_hi[4];
  wire stall = (dbg_lo[5:0] == STALL_CODE) && !rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      shadow  <= '0;
      retries <= '0;
    end else begin
      case (st)
        S_IDLE:   if (lnk) begin st <= S_SETTLE; tmr <= '0; end
        S_SETTLE: if (!lnk) st <= S_IDLE;
                  else if (tmr == SETTLE_END) st <= S_WATCH;
                  else tmr <= tmr + 1'b1;
        S_WATCH:  if (!lnk) st <= S_IDLE;
                  else if (stall) st <= S_RD_SET;
        S_RD_SET: if (phy_done) begin shadow <= phy_rdata | MASK; st <= S_WR_SET; end
        S_WR_SET: if (phy_done) begin
                    st  <= S_HOLD;
                    tmr <= '0;
                    if (retries != {CNT_W{1'b1}}) retries <= retries + 1'b1;
                  end
        S_HOLD:   if (tmr == HOLD_END) st <= S_RD_CLR;
                  else tmr <= tmr + 1'b1;
        S_RD_CLR: if (phy_done) begin shadow <= phy_rdata & ~MASK; st <= S_WR_CLR; end
        S_WR_CLR: if (phy_done) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign phy_req   = (st == S_RD_SET) || (st == S_WR_SET) || (st == S_RD_CLR) || (st == S_WR_CLR);
  assign phy_we    = (st == S_WR_SET) || (st == S_WR_CLR);
  assign phy_addr  = OVRD_ADDR;
  assign phy_wdata = shadow;
  assign stuck     = (st >= S_RD_SET);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_done |=> phy_req && $stable(phy_we) && $stable(phy_wdata));

  p_req_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> stuck);

  p_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> phy_addr == OVRD_ADDR);

  p_stuck_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> $past(lnk) && $past(dbg_lo[5:0] == STALL_CODE) && !$past(rx_valid));

  p_retry_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retries != $past(retries) |-> retries == $past(retries) + 1'b1);
endmodule

// File: tb/test_link_stall_guard.sv
module test_link_stall_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 20;
  localparam int HOLD   = 30;
  localparam int CW     = 3;
  localparam logic [5:0]  CODE = 6'h0D;
  localparam logic [15:0] MASK = 16'h0028;

  logic clk = 0, rst_n = 0;
  logic [31:0] dbg_lo = 0, dbg_hi = 0;
  logic rx_valid = 1;
  logic phy_req, phy_we, stuck;
  logic [15:0] phy_addr, phy_wdata;
  logic [15:0] phy_rdata = 0;
  logic phy_done = 0;
  logic [CW-1:0] retries;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_stall_guard #(.SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD), .CNT_W(CW)) i_link_stall_guard (
    .clk(clk), .rst_n(rst_n), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi), .rx_valid(rx_valid),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_rdata(phy_rdata), .phy_done(phy_done), .stuck(stuck), .retries(retries));

  int vectors = 0, miscompares = 0;
  int n_pulses = 0;

  // PHY register engine model
  logic [15:0] phy_reg = 0, orig_val = 0, set_val = 0;
  int trial_id = 0, seen_id = 0, nwr = 0, stuck_cnt = 0, cyc = 0;
  int t_w1 = 0, t_r2 = 0, lat = 0;
  bit busy = 0, wait_r2 = 0;
  logic [15:0] bad_addr_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (stuck) stuck_cnt++;
    if (trial_id != seen_id) begin phy_reg = orig_val; seen_id = trial_id; end
    if (!rst_n) begin busy = 0; phy_done = 0; end
    else if (phy_done) phy_done = 0;
    else if (phy_req) begin
      if (wait_r2) begin t_r2 = cyc; wait_r2 = 0; end
      if (phy_addr != 16'h1005) bad_addr_cnt++;
      if (!busy) begin busy = 1; lat = $urandom_range(0, 2); end
      if (lat == 0) begin
        phy_done = 1; busy = 0;
        if (phy_we) begin
          phy_reg = phy_wdata; nwr++;
          if ((phy_wdata & MASK) == MASK) begin set_val = phy_wdata; t_w1 = cyc; wait_r2 = 1; end
        end else phy_rdata = phy_reg;
      end else lat--;
    end
  end

  function automatic logic [15:0] exp_set(logic [15:0] v); return v | MASK; endfunction
  function automatic logic [15:0] exp_clr(logic [15:0] v); return v & ~MASK; endfunction
  function automatic int exp_retries(int n); return (n > 7) ? 7 : n; endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_writes(int target);
    while (nwr < target) @(negedge clk);
  endtask

  task automatic link(bit up);
    logic [31:0] r = $urandom;
    dbg_hi = up ? (r | 32'h10) : (r & ~32'h10);
  endtask

  task automatic set_state(logic [5:0] st);
    logic [31:0] r = $urandom;
    dbg_lo = {r[31:6], st};
  endtask

  task automatic prep_trial();
    link(0); rx_valid = 1;
    repeat (3) @(negedge clk);
    orig_val = 16'($urandom);
    trial_id++;
    @(negedge clk);
  endtask

  task automatic check_pulse(int w0, string tag);
    chk(nwr == w0 + 2, {tag, " R5/R7 write count"}, nwr - w0, 2);
    chk(set_val == exp_set(orig_val), "R5 set value", set_val, exp_set(orig_val));
    chk(phy_reg == exp_clr(orig_val), "R7 cleared value", phy_reg, exp_clr(orig_val));
    chk(t_r2 - t_w1 == HOLD + 1, "R6 hold spacing", t_r2 - t_w1, HOLD + 1);
    chk(retries == exp_retries(n_pulses), "R9 retry count", retries, exp_retries(n_pulses));
  endtask

  task automatic random_trial();
    int w0, s0;
    bit do_stall = ($urandom % 3) != 0;
    prep_trial();
    w0 = nwr;
    if (do_stall) begin set_state(CODE); rx_valid = 0; end
    else if ($urandom % 2) begin set_state(CODE); rx_valid = 1; end
    else begin set_state(CODE ^ 6'(1 + $urandom % 63)); rx_valid = 1'($urandom); end
    link(1);
    s0 = stuck_cnt;
    if (do_stall) begin
      wait_writes(w0 + 1);
      n_pulses++;
      wait_writes(w0 + 2);
      @(negedge clk); rx_valid = 1;
      repeat (SETTLE + 10) @(negedge clk);
      check_pulse(w0, "R4");
    end else begin
      repeat (SETTLE + HOLD + 20) @(negedge clk);
      chk(nwr == w0, "R4 no recovery without stall", nwr - w0, 0);
      chk(stuck_cnt == s0, "R2/R4 stuck stays low", stuck_cnt - s0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    set_state(6'h00);
    repeat (3) @(negedge clk);
    chk(stuck == 0, "R1 stuck reset", stuck, 0);
    chk(retries == 0, "R1 retries reset", retries, 0);
    chk(phy_req == 0, "R1 req reset", phy_req, 0);
    rst_n = 1;

    // R3 exact timing, R10 link drop during hold
    begin
      int w0;
      prep_trial(); w0 = nwr;
      set_state(CODE); rx_valid = 0; link(1);
      repeat (SETTLE + 1) @(posedge clk);
      @(negedge clk) chk(stuck == 0, "R3 no action before settle", stuck, 0);
      @(posedge clk); @(negedge clk) chk(stuck == 1, "R3 stuck after settle", stuck, 1);
      wait_writes(w0 + 1); n_pulses++;
      link(0);
      wait_writes(w0 + 2);
      check_pulse(w0, "R10");
      repeat (2) @(negedge clk);
      chk(stuck == 0, "R8 stuck drops after clear", stuck, 0);
      repeat (SETTLE + 10) @(negedge clk);
      chk(nwr == w0 + 2, "R10 no recheck with link down", nwr - w0, 2);
      rx_valid = 1;
    end

    // R3 restart of settle count after a link glitch
    begin
      int w0;
      prep_trial(); w0 = nwr;
      set_state(CODE); rx_valid = 0; link(1);
      repeat (SETTLE - 2) @(negedge clk);
      link(0); @(negedge clk); link(1);
      repeat (SETTLE + 1) @(posedge clk);
      @(negedge clk) chk(stuck == 0, "R3 settle restarts after glitch", stuck, 0);
      @(posedge clk); @(negedge clk) chk(stuck == 1, "R3 stuck after restarted settle", stuck, 1);
      wait_writes(w0 + 1); n_pulses++;
      wait_writes(w0 + 2);
      @(negedge clk); rx_valid = 1;
      check_pulse(w0, "R3");
    end

    // R4 link loss in the same cycle as a stall
    begin
      int w0, s0;
      prep_trial(); w0 = nwr;
      set_state(CODE); rx_valid = 1; link(1);
      repeat (SETTLE + 5) @(negedge clk);
      s0 = stuck_cnt;
      rx_valid = 0; link(0);
      repeat (SETTLE + 10) @(negedge clk);
      chk(nwr == w0, "R4 link loss wins over stall", nwr - w0, 0);
      chk(stuck_cnt == s0, "R4 stuck stays low on link loss", stuck_cnt - s0, 0);
      chk(retries == exp_retries(n_pulses), "R4 retries unchanged", retries, exp_retries(n_pulses));
      rx_valid = 1;
    end

    for (int i = 0; i < 14; i++) random_trial();

    // R9 saturation
    while (n_pulses < 10) begin
      int w0;
      prep_trial(); w0 = nwr;
      set_state(CODE); rx_valid = 0; link(1);
      wait_writes(w0 + 1); n_pulses++;
      wait_writes(w0 + 2);
      @(negedge clk); rx_valid = 1;
      repeat (3) @(negedge clk);
      chk(retries == exp_retries(n_pulses), "R9 saturating count", retries, exp_retries(n_pulses));
    end
    chk(bad_addr_cnt == 0, "R5 address of every access", bad_addr_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule